// File: doc/BRIEF.md
# Privileged-Mode Shadowed Integer Register File

This block is a 64-bit integer register file addressed by 5-bit register numbers (0 to 31). It has two combinational read ports and one write port. A single `priv_mode` input selects a banking view. While `priv_mode` is high, eight of the register numbers stop reaching the normal array and reach a separate 8-entry shadow bank instead. Privileged handler code can then use those numbers as scratch space without saving the interrupted program's values. While `priv_mode` is low, every number reaches the normal array.

Register number 31 is a hard-wired zero in both views. Both read ports and the write port pass through the same number-to-storage mapping, each using the `priv_mode` value present in the cycle of the access. Reads show the stored contents, with no bypass from a write in the same cycle. The block is a plain storage element with no state machine: its only sequential behaviour is the write commit at the clock edge and the clearing of both banks on reset.

Top module: `priv_shadow_regfile`

## Requirements
- R1: With `priv_mode` low, every register number 0 to 30 reads and writes its own entry of the normal array on both read ports.
- R2: With `priv_mode` high, register numbers 8 to 14 read and write shadow entries 0 to 6, in increasing order (number 8 maps to entry 0).
- R3: With `priv_mode` high, register number 25 reads and writes shadow entry 7.
- R4: With `priv_mode` high, register numbers other than 8 to 14, 25 and 31 reach the same normal-array entry as with `priv_mode` low, so values are shared between the two views.
- R5: A write to a shadowed number (8 to 14 or 25) with `priv_mode` high does not change what that number reads with `priv_mode` low, and the reverse also holds.
- R6: Register 31 reads zero on both ports in both views, and a write to it is discarded.
- R7: The mapping uses the `priv_mode` value of the current cycle: reads follow a mode change in the same cycle, without a clock edge.
- R8: After reset, every register number reads zero in both views.
- R9: A read of the register being written in the same cycle returns the old value. The new value is read from the cycle after the write.
- R10: The two read ports are independent, and they return equal data when given the same register number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears both banks |
| priv_mode | input | 1 | High selects the shadowed view for this cycle's accesses |
| rd_a_idx | input | 5 | Register number for read port A |
| rd_a_data | output | 64 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Register number for read port B |
| rd_b_data | output | 64 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register number for the write |
| wr_data | input | 64 | Write data |

## Verification
The hardest situation to expose from the ports is a mapping error that leaves each view self-consistent but makes the views leak into each other. An example is a shadow write that also lands in the normal entry, or a shared register that is split by mistake. To reach it, the stimulus first fills every register number with a distinct value in the normal view. It then overwrites every number in the privileged view with a second distinct set, and sweeps all 32 numbers through both ports in both views. Shadowed numbers must then show different values in the two views, and shared numbers must show the privileged value in both. A same-cycle write/read on one number, and a mode flip under a fixed read number, cover the cases where timing rather than mapping is at fault.

// File: rtl/prf_pkg.sv
package prf_pkg;

    // Where a register number resolves to after banking.
    typedef enum logic [1:0] {
        SEL_MAIN   = 2'd0,
        SEL_SHADOW = 2'd1,
        SEL_ZERO   = 2'd2
    } prf_sel_e;

endpackage

// File: rtl/prf_map.sv
module prf_map
    import prf_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int SH_LO    = 8,
    parameter int SH_CNT   = 7,
    parameter int SH_EXTRA = 25,
    localparam int AW      = $clog2(NREG),
    localparam int NSH     = SH_CNT + 1,
    localparam int SW      = $clog2(NSH)
) (
    input  logic [AW-1:0] idx,
    input  logic          priv,
    output prf_sel_e      sel,
    output logic [SW-1:0] sh_idx
);

    localparam logic [AW-1:0] ZERO_IDX = AW'(NREG - 1);
    localparam logic [AW-1:0] RUN_LO   = AW'(SH_LO);
    localparam logic [AW-1:0] RUN_END  = AW'(SH_LO + SH_CNT);
    localparam logic [AW-1:0] EXTRA    = AW'(SH_EXTRA);

    logic in_run;
    logic [AW-1:0] run_off;

    assign in_run  = (idx >= RUN_LO) && (idx < RUN_END);
    assign run_off = idx - RUN_LO;

    always_comb begin
        sel    = SEL_MAIN;
        sh_idx = '0;
        if (idx == ZERO_IDX) begin
            sel = SEL_ZERO;
        end else if (priv && in_run) begin
            sel    = SEL_SHADOW;
            sh_idx = run_off[SW-1:0];
        end else if (priv && (idx == EXTRA)) begin
            sel    = SEL_SHADOW;
            sh_idx = SW'(SH_CNT);
        end
    end

endmodule

// File: rtl/prf_bank.sv
module prf_bank #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    ra_addr,
    output logic [WIDTH-1:0] ra_data,
    input  logic [AW-1:0]    rb_addr,
    output logic [WIDTH-1:0] rb_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (we && (waddr == AW'(i))) begin
                    mem[i] <= wdata;
                end
            end
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

endmodule

// File: rtl/priv_shadow_regfile.sv
module priv_shadow_regfile
    import prf_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int NREG     = 32,
    parameter int SH_LO    = 8,
    parameter int SH_CNT   = 7,
    parameter int SH_EXTRA = 25,
    localparam int AW      = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            priv_mode,
    input  logic [AW-1:0]   rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [AW-1:0]   rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data
);

    localparam int NSH = SH_CNT + 1;
    localparam int SW  = $clog2(NSH);
    localparam int NRD = 2;

    // Read ports gathered into arrays so the per-port logic is generated.
    logic [AW-1:0]   rp_idx  [NRD];
    logic [XLEN-1:0] rp_data [NRD];
    prf_sel_e        rp_sel  [NRD];
    logic [SW-1:0]   rp_sh   [NRD];
    logic [XLEN-1:0] main_q  [NRD];
    logic [XLEN-1:0] sh_q    [NRD];

    assign rp_idx[0] = rd_a_idx;
    assign rp_idx[1] = rd_b_idx;
    assign rd_a_data = rp_data[0];
    assign rd_b_data = rp_data[1];

    // Write-side mapping.
    prf_sel_e      w_sel;
    logic [SW-1:0] w_sh;

    prf_map #(
        .NREG(NREG), .SH_LO(SH_LO), .SH_CNT(SH_CNT), .SH_EXTRA(SH_EXTRA)
    ) u_wmap (
        .idx    (wr_idx),
        .priv   (priv_mode),
        .sel    (w_sel),
        .sh_idx (w_sh)
    );

    logic main_we;
    logic sh_we;
    assign main_we = wr_en && (w_sel == SEL_MAIN);
    assign sh_we   = wr_en && (w_sel == SEL_SHADOW);

    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rport
            prf_map #(
                .NREG(NREG), .SH_LO(SH_LO), .SH_CNT(SH_CNT), .SH_EXTRA(SH_EXTRA)
            ) u_rmap (
                .idx    (rp_idx[r]),
                .priv   (priv_mode),
                .sel    (rp_sel[r]),
                .sh_idx (rp_sh[r])
            );

            always_comb begin
                unique case (rp_sel[r])
                    SEL_MAIN:   rp_data[r] = main_q[r];
                    SEL_SHADOW: rp_data[r] = sh_q[r];
                    default:    rp_data[r] = '0;
                endcase
            end
        end
    endgenerate

    prf_bank #(.WIDTH(XLEN), .DEPTH(NREG)) u_main (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (main_we),
        .waddr   (wr_idx),
        .wdata   (wr_data),
        .ra_addr (rp_idx[0]),
        .ra_data (main_q[0]),
        .rb_addr (rp_idx[1]),
        .rb_data (main_q[1])
    );

    prf_bank #(.WIDTH(XLEN), .DEPTH(NSH)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (sh_we),
        .waddr   (w_sh),
        .wdata   (wr_data),
        .ra_addr (rp_sh[0]),
        .ra_data (sh_q[0]),
        .rb_addr (rp_sh[1]),
        .rb_data (sh_q[1])
    );

endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
    parameter int XLEN = 64,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            priv_mode,
    input logic [AW-1:0]   rd_a_idx,
    input logic [XLEN-1:0] rd_a_data,
    input logic [AW-1:0]   rd_b_idx,
    input logic [XLEN-1:0] rd_b_data,
    input logic            wr_en,
    input logic [AW-1:0]   wr_idx,
    input logic [XLEN-1:0] wr_data
);

    localparam logic [AW-1:0] ZERO_IDX = {AW{1'b1}};

    logic started;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (rd_a_data == '0 && rd_b_data == '0));

    p_zero_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == ZERO_IDX) |-> (rd_a_data == '0));

    p_zero_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == ZERO_IDX) |-> (rd_b_data == '0));

    p_ports_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

    p_write_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != ZERO_IDX) |=>
            (rd_a_idx != $past(wr_idx) || priv_mode != $past(priv_mode) ||
             rd_a_data == $past(wr_data)));

    p_no_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $stable(rd_a_idx) && $stable(priv_mode) && !$past(wr_en))
            |-> $stable(rd_a_data));

endmodule

bind priv_shadow_regfile prf_checker #(.XLEN(XLEN), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .priv_mode (priv_mode),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
);

// File: tb/priv_shadow_regfile_tb.sv
module priv_shadow_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv_mode = 1'b0;
    logic [4:0]  rd_a_idx = '0;
    logic [63:0] rd_a_data;
    logic [4:0]  rd_b_idx = '0;
    logic [63:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [63:0] m_main [32];
    logic [63:0] m_sh   [8];

    always #5 clk = ~clk;

    priv_shadow_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    // Shadow target per R2/R3: -1 means the normal array.
    function automatic int sh_slot(bit m, int i);
        if (!m) return -1;
        if (i >= 8 && i <= 14) return i - 8;
        if (i == 25) return 7;
        return -1;
    endfunction

    function automatic logic [63:0] expect_rd(bit m, int i);
        int s;
        if (i == 31) return 64'd0;
        s = sh_slot(m, i);
        if (s >= 0) return m_sh[s];
        return m_main[i];
    endfunction

    function automatic string tag_of(bit m, int i);
        if (i == 31) return "R6";
        if (i == 25 && m) return "R3";
        if (sh_slot(m, i) >= 0) return "R2";
        if (i == 25 || (i >= 8 && i <= 14)) return "R5";
        return m ? "R4" : "R1";
    endfunction

    function automatic logic [63:0] val_norm(int i);
        return 64'h1111_0000_0000_0000 + 64'(i) * 64'h0000_0001_0001_0003;
    endfunction

    function automatic logic [63:0] val_priv(int i);
        return 64'hC0DE_0000_0000_0000 ^ (64'(i) * 64'h0000_0100_0010_0001);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(bit m, int i, logic [63:0] v);
        int s;
        @(negedge clk);
        priv_mode = m; wr_en = 1'b1; wr_idx = 5'(i); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        if (i != 31) begin
            s = sh_slot(m, i);
            if (s >= 0) m_sh[s] = v;
            else        m_main[i] = v;
        end
    endtask

    task automatic read_both(bit m, int ia, int ib, string tag);
        @(negedge clk);
        priv_mode = m; rd_a_idx = 5'(ia); rd_b_idx = 5'(ib);
        #1;
        check(tag, rd_a_data, expect_rd(m, ia));
        check(tag, rd_b_data, expect_rd(m, ib));
    endtask

    task automatic sweep(string prefix);
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 32; i++) begin
                read_both(bit'(m), i, 31 - i,
                          $sformatf("%s %s/R10 mode=%0d idx=%0d", prefix,
                                    tag_of(bit'(m), i), m, i));
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_main[i] = '0;
        for (int i = 0; i < 8; i++)  m_sh[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: all zero after reset in both views
        sweep("R8 reset");

        // Fill the normal view, then overwrite every number in the privileged view
        for (int i = 0; i < 32; i++) do_write(1'b0, i, val_norm(i));
        for (int i = 0; i < 32; i++) do_write(1'b1, i, val_priv(i));
        sweep("fill");

        // R5: shadowed number 9 differs between views; R4: number 7 shared
        read_both(1'b0, 9, 9, "R5 norm idx9");
        check("R5 norm idx9 value", rd_a_data, val_norm(9));
        read_both(1'b1, 9, 25, "R5 priv idx9");
        check("R5 priv idx9 value", rd_a_data, val_priv(9));
        check("R3 priv idx25 value", rd_b_data, val_priv(25));
        read_both(1'b0, 7, 26, "R4 shared");
        check("R4 idx7 norm shows priv write", rd_a_data, val_priv(7));

        // R5 reverse: normal write to 12 leaves the shadow copy
        do_write(1'b0, 12, 64'hDEAD_BEEF_0000_0012);
        read_both(1'b1, 12, 12, "R5 priv idx12 after norm write");
        check("R5 shadow idx12 untouched", rd_a_data, val_priv(12));

        // R7: mode flip under a fixed read number, no clock edge in between
        @(negedge clk);
        rd_a_idx = 5'd12; rd_b_idx = 5'd12; priv_mode = 1'b0;
        #1;
        check("R7 idx12 norm", rd_a_data, 64'hDEAD_BEEF_0000_0012);
        priv_mode = 1'b1;
        #1;
        check("R7 idx12 priv same cycle", rd_a_data, val_priv(12));

        // R6: writes to 31 discarded in both modes
        do_write(1'b0, 31, 64'hFFFF_FFFF_FFFF_FFFF);
        do_write(1'b1, 31, 64'h1234_5678_9ABC_DEF0);
        read_both(1'b0, 31, 31, "R6 zero norm");
        read_both(1'b1, 31, 31, "R6 zero priv");
        check("R6 literal zero", rd_a_data, 64'd0);

        // R9: same-cycle read returns old value, new one next cycle
        @(negedge clk);
        priv_mode = 1'b1; rd_a_idx = 5'd13; rd_b_idx = 5'd5;
        wr_en = 1'b1; wr_idx = 5'd13; wr_data = 64'h0BAD_CAFE_0000_0013;
        #1;
        check("R9 old value during write", rd_a_data, val_priv(13));
        @(negedge clk);
        wr_en = 1'b0;
        m_sh[5] = 64'h0BAD_CAFE_0000_0013;
        #1;
        check("R9 new value after write", rd_a_data, 64'h0BAD_CAFE_0000_0013);

        // Final sweep over the updated state
        sweep("final");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule